// File: doc/BRIEF.md
# Security Attribute Access Filter

This block decides, for each bus request presented to it, whether the request may proceed. A request targets either a peripheral slot or a memory zone. A peripheral slot has a 2-bit protection attribute. The attribute is combined with three properties of the transaction: whether it is secure, whether it is a write, and which initiator issued it. A memory zone is described by three values: a base address, a page count and a split value. The pages below the split are reachable only by secure accesses. The pages at or above the split are open to everyone. A page is 4 KiB.

The attributes, bases, page counts and splits are supplied as inputs by surrounding configuration logic. The block stores none of them. It raises no bus error itself; it only reports allow or deny. Each request qualified by `req_valid` is decided combinationally. The result is captured into a three-state response machine, so the decision appears on the clock edge after the request, together with a valid flag.

The response machine has the states IDLE (no result), GRANT (the previous request was allowed) and DENY (the previous request was refused). Its transitions are:
- REQ_OK: from any state to GRANT when a valid request is allowed.
- REQ_BAD: from any state to DENY when a valid request is refused.
- NO_REQ: from any state to IDLE when no request is presented.

Top module: `sec_access_filter`

## Requirements
- R1: When `req_valid` is high at a rising edge, `rsp_valid` is high after that edge; otherwise `rsp_valid` is low. `rsp_allow` is never high while `rsp_valid` is low. Back-to-back requests give back-to-back responses.
- R2: Peripheral attribute 2'b00 (secure only) allows secure reads and secure writes, and denies every non-secure access.
- R3: Peripheral attribute 2'b01 (shared read) allows non-secure reads, denies non-secure writes, and allows all secure accesses.
- R4: Peripheral attribute 2'b11 (open) allows every access.
- R5: Peripheral attribute 2'b10 (coprocessor-owned) allows an access exactly when `req_master` equals `COPRO_ID`, whatever the secure and direction flags.
- R6: A peripheral request (`req_is_mem` = 0) whose `req_target` is not below `NUM_PERIPH` is denied.
- R7: A memory request (`req_is_mem` = 1) is denied when `req_zone` is not below `NUM_ZONES`. It is also denied when `req_addr` lies outside [base, base + pages*4096) of the selected zone.
- R8: A secure memory access anywhere inside the selected zone is allowed, for reads and writes alike.
- R9: A non-secure memory access inside the zone is allowed exactly when `req_addr - base >= split*4096`. The last byte below that boundary is denied and the boundary byte itself is allowed.
- R10: A split of 0 opens the whole zone to non-secure accesses. A split equal to or above the zone page count makes the whole zone secure-only.
- R11: While `rst_n` is low, `rsp_valid` and `rsp_allow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_mem | input | 1 | 1: memory zone request, 0: peripheral request |
| req_secure | input | 1 | Transaction is secure |
| req_write | input | 1 | Transaction is a write |
| req_master | input | ID_W | Initiator identity |
| req_target | input | TGT_W | Peripheral slot index |
| req_zone | input | ZSEL_W | Memory zone index |
| req_addr | input | ADDR_W | Transaction address |
| cfg_attr | input | NUM_PERIPH*2 | Attribute of slot i at bits [2i+1:2i] |
| cfg_zone_base | input | NUM_ZONES*ADDR_W | Base address of each zone |
| cfg_zone_pages | input | NUM_ZONES*SIZE_W | Zone length in 4 KiB pages |
| cfg_zone_split | input | NUM_ZONES*SIZE_W | Secure-only page count from zone base |
| rsp_valid | output | 1 | Decision present |
| rsp_allow | output | 1 | Decision: 1 allow, 0 deny |

## Verification
Every decision is due one rising edge after the request is presented, and no result is ever due in the request's own cycle. The bench drives each request at a falling edge. It samples `rsp_valid` and `rsp_allow` at the next falling edge, which is half a period after the capturing edge. For the idle check, the bench drops `req_valid` and samples one falling edge later, so that it sees the IDLE state. Back-to-back requests are sampled on consecutive falling edges, each against its own expected decision.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int PAGE_SHIFT = 12;

    typedef enum logic [1:0] {
        ATTR_SEC_ONLY = 2'b00,
        ATTR_NS_READ  = 2'b01,
        ATTR_COPRO    = 2'b10,
        ATTR_OPEN     = 2'b11
    } attr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GRANT = 2'b01,
        ST_DENY  = 2'b10
    } rsp_state_e;

endpackage

// File: rtl/sfa_periph_policy.sv
module sfa_periph_policy
    import sfa_pkg::*;
#(
    parameter int ID_W = 4,
    parameter logic [ID_W-1:0] COPRO_ID = '0
) (
    input  attr_e           attr,
    input  logic            secure,
    input  logic            write,
    input  logic [ID_W-1:0] master,
    output logic            allow
);

    always_comb begin
        unique case (attr)
            ATTR_SEC_ONLY: allow = secure;
            ATTR_NS_READ:  allow = secure | ~write;
            ATTR_COPRO:    allow = (master == COPRO_ID);
            ATTR_OPEN:     allow = 1'b1;
            default:       allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/sfa_zone_check.sv
module sfa_zone_check
    import sfa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 10
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SIZE_W-1:0] pages,
    input  logic [SIZE_W-1:0] split,
    input  logic [ADDR_W-1:0] addr,
    input  logic              secure,
    output logic              allow
);

    localparam int LIM_W = SIZE_W + PAGE_SHIFT;
    localparam int CMP_W = (ADDR_W > LIM_W) ? ADDR_W : LIM_W;

    logic [ADDR_W-1:0] offset;
    logic [CMP_W-1:0]  off_ext;
    logic [CMP_W-1:0]  zone_lim;
    logic [CMP_W-1:0]  sec_lim;
    logic              in_zone;
    logic              in_open_part;

    always_comb begin
        offset       = addr - base;
        off_ext      = CMP_W'(offset);
        zone_lim     = CMP_W'({pages, {PAGE_SHIFT{1'b0}}});
        sec_lim      = CMP_W'({split, {PAGE_SHIFT{1'b0}}});
        in_zone      = (addr >= base) && (off_ext < zone_lim);
        in_open_part = (off_ext >= sec_lim);
        allow        = in_zone && (secure || in_open_part);
    end

endmodule

// File: rtl/sfa_resp_fsm.sv
module sfa_resp_fsm
    import sfa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic decide_allow,
    output logic rsp_valid,
    output logic rsp_allow
);

    rsp_state_e state_q;
    rsp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (!req_valid) begin
                    state_d = ST_IDLE;
                end else if (decide_allow) begin
                    state_d = ST_GRANT;
                end else begin
                    state_d = ST_DENY;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_GRANT: begin
                rsp_valid = 1'b1;
                rsp_allow = 1'b1;
            end
            ST_DENY: begin
                rsp_valid = 1'b1;
                rsp_allow = 1'b0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_allow = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sec_access_filter.sv
module sec_access_filter
    import sfa_pkg::*;
#(
    parameter int NUM_PERIPH = 12,
    parameter int TGT_W      = 4,
    parameter int NUM_ZONES  = 2,
    parameter int ZSEL_W     = 2,
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 10,
    parameter int ID_W       = 4,
    parameter logic [ID_W-1:0] COPRO_ID = 4'd5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_is_mem,
    input  logic                        req_secure,
    input  logic                        req_write,
    input  logic [ID_W-1:0]             req_master,
    input  logic [TGT_W-1:0]            req_target,
    input  logic [ZSEL_W-1:0]           req_zone,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [NUM_PERIPH*2-1:0]     cfg_attr,
    input  logic [NUM_ZONES*ADDR_W-1:0] cfg_zone_base,
    input  logic [NUM_ZONES*SIZE_W-1:0] cfg_zone_pages,
    input  logic [NUM_ZONES*SIZE_W-1:0] cfg_zone_split,
    output logic                        rsp_valid,
    output logic                        rsp_allow
);

    logic [1:0]           attr_sel;
    logic                 tgt_in_range;
    logic                 periph_ok;
    logic [NUM_ZONES-1:0] zone_ok;
    logic                 zone_sel_ok;
    logic                 decide_allow;

    always_comb begin
        attr_sel     = 2'b00;
        tgt_in_range = 1'b0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if ({1'b0, req_target} == (TGT_W+1)'(i)) begin
                attr_sel     = cfg_attr[2*i +: 2];
                tgt_in_range = 1'b1;
            end
        end
    end

    sfa_periph_policy #(
        .ID_W     (ID_W),
        .COPRO_ID (COPRO_ID)
    ) u_policy (
        .attr   (attr_e'(attr_sel)),
        .secure (req_secure),
        .write  (req_write),
        .master (req_master),
        .allow  (periph_ok)
    );

    generate
        for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
            sfa_zone_check #(
                .ADDR_W (ADDR_W),
                .SIZE_W (SIZE_W)
            ) u_zone (
                .base   (cfg_zone_base[z*ADDR_W +: ADDR_W]),
                .pages  (cfg_zone_pages[z*SIZE_W +: SIZE_W]),
                .split  (cfg_zone_split[z*SIZE_W +: SIZE_W]),
                .addr   (req_addr),
                .secure (req_secure),
                .allow  (zone_ok[z])
            );
        end
    endgenerate

    always_comb begin
        zone_sel_ok = 1'b0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if ({1'b0, req_zone} == (ZSEL_W+1)'(z)) begin
                zone_sel_ok = zone_ok[z];
            end
        end
        decide_allow = req_is_mem ? zone_sel_ok : (tgt_in_range && periph_ok);
    end

    sfa_resp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .decide_allow (decide_allow),
        .rsp_valid    (rsp_valid),
        .rsp_allow    (rsp_allow)
    );

endmodule

// File: rtl/sec_access_filter_chk.sv
module sec_access_filter_chk #(
    parameter int NUM_PERIPH = 12,
    parameter int TGT_W      = 4,
    parameter int NUM_ZONES  = 2,
    parameter int ZSEL_W     = 2,
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 10,
    parameter int ID_W       = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_is_mem,
    input logic                        req_secure,
    input logic                        req_write,
    input logic [ID_W-1:0]             req_master,
    input logic [TGT_W-1:0]            req_target,
    input logic [ZSEL_W-1:0]           req_zone,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [NUM_PERIPH*2-1:0]     cfg_attr,
    input logic [NUM_ZONES*ADDR_W-1:0] cfg_zone_base,
    input logic [NUM_ZONES*SIZE_W-1:0] cfg_zone_pages,
    input logic [NUM_ZONES*SIZE_W-1:0] cfg_zone_split,
    input logic                        rsp_valid,
    input logic                        rsp_allow
);

    logic [1:0] tgt_attr;
    logic       tgt_known;
    logic       zone_known;

    always_comb begin
        tgt_attr  = 2'b00;
        tgt_known = 1'b0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if ({1'b0, req_target} == (TGT_W+1)'(i)) begin
                tgt_attr  = cfg_attr[2*i +: 2];
                tgt_known = 1'b1;
            end
        end
        zone_known = ({1'b0, req_zone} < (ZSEL_W+1)'(NUM_ZONES));
    end

    AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_REQ_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_ALLOW_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> rsp_valid); // R1
    AST_SEC_ONLY_BLOCKS_NS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mem && tgt_known && tgt_attr == 2'b00 && !req_secure) |=> !rsp_allow); // R2
    AST_NS_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mem && tgt_known && tgt_attr == 2'b01 && !req_secure && req_write) |=> !rsp_allow); // R3
    AST_OPEN_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mem && tgt_known && tgt_attr == 2'b11) |=> rsp_allow); // R4
    AST_BAD_TARGET_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mem && !tgt_known) |=> (rsp_valid && !rsp_allow)); // R6
    AST_BAD_ZONE_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mem && !zone_known) |=> (rsp_valid && !rsp_allow)); // R7

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!rsp_valid && !rsp_allow); // R11
        end
    end

endmodule

bind sec_access_filter sec_access_filter_chk #(
    .NUM_PERIPH (NUM_PERIPH),
    .TGT_W      (TGT_W),
    .NUM_ZONES  (NUM_ZONES),
    .ZSEL_W     (ZSEL_W),
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .ID_W       (ID_W)
) u_chk (.*);

// File: tb/sec_access_filter_test.sv
`timescale 1ns/1ps
module sec_access_filter_test;

    localparam int NUM_PERIPH = 12;
    localparam int TGT_W      = 4;
    localparam int NUM_ZONES  = 2;
    localparam int ZSEL_W     = 2;
    localparam int ADDR_W     = 32;
    localparam int SIZE_W     = 10;
    localparam int ID_W       = 4;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        req_valid = 1'b0;
    logic                        req_is_mem = 1'b0;
    logic                        req_secure = 1'b0;
    logic                        req_write = 1'b0;
    logic [ID_W-1:0]             req_master = '0;
    logic [TGT_W-1:0]            req_target = '0;
    logic [ZSEL_W-1:0]           req_zone = '0;
    logic [ADDR_W-1:0]           req_addr = '0;
    logic [NUM_PERIPH*2-1:0]     cfg_attr = '0;
    logic [NUM_ZONES*ADDR_W-1:0] cfg_zone_base = '0;
    logic [NUM_ZONES*SIZE_W-1:0] cfg_zone_pages = '0;
    logic [NUM_ZONES*SIZE_W-1:0] cfg_zone_split = '0;
    logic                        rsp_valid;
    logic                        rsp_allow;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sec_access_filter #(
        .NUM_PERIPH (NUM_PERIPH), .TGT_W (TGT_W), .NUM_ZONES (NUM_ZONES),
        .ZSEL_W (ZSEL_W), .ADDR_W (ADDR_W), .SIZE_W (SIZE_W), .ID_W (ID_W),
        .COPRO_ID (4'd5)
    ) uut (.*);

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic send(logic mem, logic sec, logic wr, logic [ID_W-1:0] mst,
                        logic [TGT_W-1:0] tgt, logic [ZSEL_W-1:0] zn,
                        logic [ADDR_W-1:0] addr, logic exp, string tag);
        req_valid  = 1'b1;
        req_is_mem = mem;
        req_secure = sec;
        req_write  = wr;
        req_master = mst;
        req_target = tgt;
        req_zone   = zn;
        req_addr   = addr;
        @(negedge clk);
        check_bit({tag, " valid"}, rsp_valid, 1'b1);
        check_bit({tag, " allow"}, rsp_allow, exp);
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_bit("R11 reset valid", rsp_valid, 1'b0);
        check_bit("R11 reset allow", rsp_allow, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sec_only();
        send(0, 1, 0, 4'd0, 4'd0, 0, 0, 1'b1, "R2 secure read");
        send(0, 1, 1, 4'd0, 4'd0, 0, 0, 1'b1, "R2 secure write");
        send(0, 0, 0, 4'd0, 4'd0, 0, 0, 1'b0, "R2 ns read");
        send(0, 0, 1, 4'd5, 4'd0, 0, 0, 1'b0, "R2 ns write");
        go_idle();
    endtask

    task automatic t_ns_read();
        send(0, 0, 0, 4'd1, 4'd1, 0, 0, 1'b1, "R3 ns read");
        send(0, 0, 1, 4'd1, 4'd1, 0, 0, 1'b0, "R3 ns write");
        send(0, 1, 1, 4'd1, 4'd1, 0, 0, 1'b1, "R3 secure write");
        send(0, 1, 0, 4'd1, 4'd1, 0, 0, 1'b1, "R3 secure read");
        go_idle();
    endtask

    task automatic t_open();
        send(0, 0, 1, 4'd2, 4'd3, 0, 0, 1'b1, "R4 ns write");
        send(0, 1, 0, 4'd9, 4'd3, 0, 0, 1'b1, "R4 secure read");
        go_idle();
    endtask

    task automatic t_copro();
        send(0, 0, 1, 4'd5, 4'd2, 0, 0, 1'b1, "R5 copro ns write");
        send(0, 1, 0, 4'd5, 4'd2, 0, 0, 1'b1, "R5 copro secure read");
        send(0, 1, 0, 4'd3, 4'd2, 0, 0, 1'b0, "R5 other secure read");
        send(0, 0, 0, 4'd4, 4'd2, 0, 0, 1'b0, "R5 other ns read");
        go_idle();
    endtask

    task automatic t_bad_target();
        send(0, 1, 0, 4'd0, 4'd11, 0, 0, 1'b1, "R6 last slot open");
        send(0, 1, 0, 4'd0, 4'd12, 0, 0, 1'b0, "R6 slot 12");
        send(0, 0, 0, 4'd0, 4'd15, 0, 0, 1'b0, "R6 slot 15");
        go_idle();
    endtask

    task automatic t_zone_split();
        send(1, 0, 0, 0, 0, 2'd0, 32'h1000_3FFF, 1'b0, "R9 ns last secure byte");
        send(1, 0, 1, 0, 0, 2'd0, 32'h1000_4000, 1'b1, "R9 ns split byte");
        send(1, 0, 0, 0, 0, 2'd0, 32'h1000_0000, 1'b0, "R9 ns base");
        send(1, 0, 0, 0, 0, 2'd0, 32'h1000_FFFF, 1'b1, "R9 ns top byte");
        send(1, 1, 1, 0, 0, 2'd0, 32'h1000_0000, 1'b1, "R8 secure write base");
        send(1, 1, 0, 0, 0, 2'd0, 32'h1000_8000, 1'b1, "R8 secure read open part");
        go_idle();
    endtask

    task automatic t_outside();
        send(1, 1, 0, 0, 0, 2'd0, 32'h1001_0000, 1'b0, "R7 just above zone");
        send(1, 1, 0, 0, 0, 2'd0, 32'h0FFF_FFFF, 1'b0, "R7 just below zone");
        send(1, 1, 0, 0, 0, 2'd2, 32'h1000_0000, 1'b0, "R7 zone index 2");
        go_idle();
    endtask

    task automatic t_extremes();
        cfg_zone_split[SIZE_W +: SIZE_W] = 10'd0;
        send(1, 0, 1, 0, 0, 2'd1, 32'h2000_0000, 1'b1, "R10 split 0 ns base");
        cfg_zone_split[SIZE_W +: SIZE_W] = 10'd8;
        send(1, 0, 0, 0, 0, 2'd1, 32'h2000_7FFF, 1'b0, "R10 split=pages ns top");
        send(1, 1, 0, 0, 0, 2'd1, 32'h2000_7FFF, 1'b1, "R10 split=pages secure top");
        cfg_zone_split[SIZE_W +: SIZE_W] = 10'd12;
        send(1, 0, 0, 0, 0, 2'd1, 32'h2000_7000, 1'b0, "R10 split>pages ns");
        go_idle();
    endtask

    task automatic t_timing();
        send(0, 1, 0, 0, 4'd0, 0, 0, 1'b1, "R1 back-to-back first");
        send(0, 0, 0, 0, 4'd0, 0, 0, 1'b0, "R1 back-to-back second");
        go_idle();
        check_bit("R1 idle valid", rsp_valid, 1'b0);
        check_bit("R1 idle allow", rsp_allow, 1'b0);
    endtask

    initial begin
        cfg_attr[1:0] = 2'b00;
        cfg_attr[3:2] = 2'b01;
        cfg_attr[5:4] = 2'b10;
        cfg_attr[7:6] = 2'b11;
        cfg_attr[23:22] = 2'b11;
        cfg_zone_base  = {32'h2000_0000, 32'h1000_0000};
        cfg_zone_pages = {10'd8, 10'd16};
        cfg_zone_split = {10'd4, 10'd4};
        @(negedge clk);
        t_reset();
        t_sec_only();
        t_ns_read();
        t_open();
        t_copro();
        t_bad_target();
        t_zone_split();
        t_outside();
        t_extremes();
        t_timing();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule